// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block sequences a chip between four clocking modes (slow, normal, idle and sleep) and drives the enables of the clocking hardware around it. Software requests mode changes and module clock enables through single-cycle configuration writes. An asynchronous wake input ends the two low-power modes. The controller drives a PLL power-down, a clock-source select for an external glitch-free multiplexer, a CPU clock enable and one clock enable for each of four module groups. It also reports the current mode on a status port.

The path from slow to normal includes a lock wait. A PLL start write powers the PLL up at once. The clock source moves to the PLL only after a programmable number of oscillator cycles has passed. Idle gates only the CPU and remembers whether slow or normal was active when it was entered, so that a wake can restore that mode. Sleep gates everything and powers the PLL down, and it always wakes into slow mode. Software can then start the PLL again if the application needs it.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the status reads slow (0), the CPU clock is enabled, all four group enables are 1, the PLL is powered down (`pll_pwrdn`=1) and the source select is the oscillator (`pll_src_sel`=0).
- R2: In slow mode, a write to address 0 with data bit 0 set clears `pll_pwrdn` on that clock edge. Status and `pll_src_sel` switch to normal and PLL exactly LOCK_CYCLES rising edges after the write edge, and stay slow and oscillator before then.
- R3: In normal mode, a write to address 0 with data bit 0 clear returns the block to slow on the next edge, with `pll_pwrdn`=1 and `pll_src_sel`=0.
- R4: In slow or normal mode, a write to address 1 with bit 0 set (and bit 1 clear) enters idle (status 2). This clears the CPU enable, keeps every group enable and holds both PLL outputs at their previous values.
- R5: Wake passes through a two-flop synchronizer, so a wake level that rises between edges acts on the third rising edge. In idle, it returns the block to whichever of slow or normal was active before idle. In slow or normal, wake has no effect.
- R6: In slow or normal mode, a write to address 1 with bit 1 set enters sleep (status 3). Bit 1 takes precedence over bit 0. Sleep clears the CPU enable and all group enables, sets `pll_pwrdn`=1 and selects the oscillator.
- R7: A wake in sleep always returns to slow mode, with the PLL powered down and the group enables restored to their last written values.
- R8: A write to address 2 in slow or normal mode loads data bits [3:0] into the group enables on the next edge. The bits map to AHB peripherals (bit 0), APB peripherals (bit 1), core (bit 2) and USB (bit 3). The same write in idle or sleep is ignored.
- R9: PLL start or stop writes received in idle or sleep are ignored. The PLL outputs and the mode do not change.
- R10: Idle and sleep requests are ignored while a PLL lock wait is in progress.
- R11: A PLL stop write during the lock wait aborts it. The PLL is powered down again and the block stays in slow without ever reporting normal.
- R12: The status output encodes slow=0, normal=1, idle=2, sleep=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock of the controller |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 2 | Write address: 0 PLL control, 1 low-power request, 2 group enables |
| cfg_wdata | input | 4 | Write data |
| wake_in | input | 1 | Asynchronous wake level |
| pll_pwrdn | output | 1 | PLL power-down, 1 = off |
| pll_src_sel | output | 1 | Clock-source select, 1 = PLL, 0 = oscillator |
| cpu_clk_en | output | 1 | CPU clock enable |
| grp_clk_en | output | 4 | Module group clock enables (AHB, APB, core, USB) |
| mode_status | output | 2 | Current mode code |

## Verification
The assertions check the mode graph on every cycle. Sleep always exits to slow, and idle always exits to its recorded mode. Normal is reached only when a lock wait completes. No low-power mode begins during a lock wait. Group enables do not move while idle, and sleep keeps the PLL and all groups off. Only the bench scenarios can show the rest: the exact cycle of the normal switch, the three-edge wake latency, that configuration writes are dropped in idle and sleep, and that stored group values reappear after sleep.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int NUM_GROUPS = 4;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_PLL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LOWP = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_GRP  = 2'd2;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_IDLE   = 2'd2,
        MODE_SLEEP  = 2'd3
    } mode_e;

    typedef struct packed {
        logic                  pll_on;
        logic                  pll_off;
        logic                  idle;
        logic                  sleep;
        logic                  grp_wr;
        logic [NUM_GROUPS-1:0] grp_val;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic wr,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic [NUM_GROUPS-1:0] data);
        cmd_t c;
        c         = '0;
        c.grp_val = data;
        if (wr) begin
            unique case (addr)
                ADDR_PLL: begin
                    c.pll_on  = data[0];
                    c.pll_off = ~data[0];
                end
                ADDR_LOWP: begin
                    c.sleep = data[1];
                    c.idle  = data[0] & ~data[1];
                end
                ADDR_GRP: c.grp_wr = 1'b1;
                default: ;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_active(input mode_e m);
        return (m == MODE_SLOW) || (m == MODE_NORMAL);
    endfunction

endpackage

// File: rtl/clkmode_wake_sync.sv
module clkmode_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
    import clkmode_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd,
    input  logic  wake,
    output mode_e mode,
    output logic  pll_pwrdn,
    output logic  pll_src_sel
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    mode_e            mode_q, mode_d;
    mode_e            prev_q, prev_d;
    logic             locking_q, locking_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        mode_d    = mode_q;
        prev_d    = prev_q;
        locking_d = locking_q;
        cnt_d     = cnt_q;
        unique case (mode_q)
            MODE_SLOW: begin
                if (locking_q) begin
                    if (cmd.pll_off) begin
                        locking_d = 1'b0;
                    end else if (cnt_q == CNT_W'(1)) begin
                        locking_d = 1'b0;
                        mode_d    = MODE_NORMAL;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end else if (cmd.sleep) begin
                    mode_d = MODE_SLEEP;
                    prev_d = MODE_SLOW;
                end else if (cmd.idle) begin
                    mode_d = MODE_IDLE;
                    prev_d = MODE_SLOW;
                end else if (cmd.pll_on) begin
                    locking_d = 1'b1;
                    cnt_d     = CNT_W'(LOCK_CYCLES);
                end
            end
            MODE_NORMAL: begin
                if (cmd.sleep) begin
                    mode_d = MODE_SLEEP;
                    prev_d = MODE_NORMAL;
                end else if (cmd.idle) begin
                    mode_d = MODE_IDLE;
                    prev_d = MODE_NORMAL;
                end else if (cmd.pll_off) begin
                    mode_d = MODE_SLOW;
                end
            end
            MODE_IDLE: begin
                if (wake) mode_d = prev_q;
            end
            MODE_SLEEP: begin
                if (wake) begin
                    mode_d = MODE_SLOW;
                    prev_d = MODE_SLOW;
                end
            end
            default: mode_d = MODE_SLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_SLOW;
            prev_q    <= MODE_SLOW;
            locking_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            mode_q    <= mode_d;
            prev_q    <= prev_d;
            locking_q <= locking_d;
            cnt_q     <= cnt_d;
        end
    end

    logic on_pll;
    assign on_pll      = (mode_q == MODE_NORMAL) ||
                         (mode_q == MODE_IDLE && prev_q == MODE_NORMAL);
    assign pll_src_sel = on_pll;
    assign pll_pwrdn   = ~(on_pll | locking_q);
    assign mode        = mode_q;

    // R7: leaving sleep always lands in slow
    p_sleep_exit_slow_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MODE_SLEEP && mode_q != MODE_SLEEP) |-> mode_q == MODE_SLOW);

    // R5: leaving idle restores the recorded active mode
    p_idle_exit_prev_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MODE_IDLE && mode_q != MODE_IDLE) |-> mode_q == $past(prev_q));

    // R2: slow to normal only at the end of a lock wait
    p_normal_after_lock_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MODE_SLOW && mode_q == MODE_NORMAL) |->
            ($past(locking_q) && $past(cnt_q) == CNT_W'(1)));

    // R10: no low-power mode begins while locking
    p_no_lowpower_in_lock_r10: assert property (@(posedge clk) disable iff (rst)
        $past(locking_q) |-> is_active(mode_q));

    // R9: PLL outputs frozen while idle persists
    p_pll_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MODE_IDLE && mode_q == MODE_IDLE) |->
            ($stable(pll_pwrdn) && $stable(pll_src_sel)));
endmodule

// File: rtl/clkmode_gate_ctrl.sv
module clkmode_gate_ctrl
    import clkmode_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_t                  cmd,
    input  mode_e                 mode,
    output logic                  cpu_clk_en,
    output logic [NUM_GROUPS-1:0] grp_clk_en
);
    logic [NUM_GROUPS-1:0] grp_q;
    logic                  sleeping;

    always_ff @(posedge clk) begin
        if (rst)                                grp_q <= '1;
        else if (cmd.grp_wr && is_active(mode)) grp_q <= cmd.grp_val;
    end

    assign sleeping   = (mode == MODE_SLEEP);
    assign cpu_clk_en = is_active(mode);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_clk_en[g] = grp_q[g] & ~sleeping;
    end

    // R8: stored group enables do not move while idle or sleep persists
    p_grp_hold_lowpower_r8: assert property (@(posedge clk) disable iff (rst)
        (!is_active($past(mode)) && !is_active(mode)) |-> $stable(grp_q));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int LOCK_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [NUM_GROUPS-1:0] cfg_wdata,
    input  logic                  wake_in,
    output logic                  pll_pwrdn,
    output logic                  pll_src_sel,
    output logic                  cpu_clk_en,
    output logic [NUM_GROUPS-1:0] grp_clk_en,
    output logic [1:0]            mode_status
);
    cmd_t  cmd;
    logic  wake_s;
    mode_e mode;

    assign cmd = decode_cmd(cfg_wr, cfg_addr, cfg_wdata);

    clkmode_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wake_in),
        .sync_out (wake_s)
    );

    clkmode_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .wake        (wake_s),
        .mode        (mode),
        .pll_pwrdn   (pll_pwrdn),
        .pll_src_sel (pll_src_sel)
    );

    clkmode_gate_ctrl u_gate (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .mode       (mode),
        .cpu_clk_en (cpu_clk_en),
        .grp_clk_en (grp_clk_en)
    );

    assign mode_status = mode;

    // R6: sleep keeps everything off
    p_sleep_all_off_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_status == 2'd3) |-> (pll_pwrdn && !pll_src_sel && !cpu_clk_en && grp_clk_en == '0));

    // R4: idle keeps CPU gated but group enables untouched
    p_idle_groups_kept_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_status) == 2'd2 && mode_status == 2'd2) |-> (!cpu_clk_en && $stable(grp_clk_en)));
endmodule

// File: tb/tb_clkmode_ctrl.sv
`timescale 1ns/1ps
module tb_clkmode_ctrl;
    localparam int LOCK = 8;

    logic       clk = 0;
    logic       rst = 1;
    logic       cfg_wr = 0;
    logic [1:0] cfg_addr = 0;
    logic [3:0] cfg_wdata = 0;
    logic       wake_in = 0;
    logic       pll_pwrdn, pll_src_sel, cpu_clk_en;
    logic [3:0] grp_clk_en;
    logic [1:0] mode_status;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    clkmode_ctrl #(.LOCK_CYCLES(LOCK), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wake_in(wake_in), .pll_pwrdn(pll_pwrdn),
        .pll_src_sel(pll_src_sel), .cpu_clk_en(cpu_clk_en),
        .grp_clk_en(grp_clk_en), .mode_status(mode_status)
    );

    // op: 0 none, 1 write, 2 wake pulse
    typedef struct packed {
        logic [1:0] op;
        logic [1:0] addr;
        logic [3:0] data;
        logic [7:0] wait_n;
        logic [1:0] mode;
        logic       cpu;
        logic [3:0] grp;
        logic       pd;
        logic       src;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd2, 4'h5, 8'd0,  2'd0, 1'b1, 4'h5, 1'b1, 1'b0, 4'd8 },  // R8 write in slow
        '{2'd1, 2'd1, 4'h1, 8'd0,  2'd2, 1'b0, 4'h5, 1'b1, 1'b0, 4'd4 },  // R4 idle from slow
        '{2'd1, 2'd2, 4'hA, 8'd0,  2'd2, 1'b0, 4'h5, 1'b1, 1'b0, 4'd8 },  // R8 ignored in idle
        '{2'd1, 2'd0, 4'h1, 8'd0,  2'd2, 1'b0, 4'h5, 1'b1, 1'b0, 4'd9 },  // R9 pll start ignored
        '{2'd2, 2'd0, 4'h0, 8'd0,  2'd0, 1'b1, 4'h5, 1'b1, 1'b0, 4'd5 },  // R5 back to slow
        '{2'd1, 2'd0, 4'h1, 8'd7,  2'd0, 1'b1, 4'h5, 1'b0, 1'b0, 4'd2 },  // R2 still locking
        '{2'd0, 2'd0, 4'h0, 8'd1,  2'd1, 1'b1, 4'h5, 1'b0, 1'b1, 4'd2 },  // R2 normal now
        '{2'd1, 2'd1, 4'h1, 8'd0,  2'd2, 1'b0, 4'h5, 1'b0, 1'b1, 4'd4 },  // R4 idle from normal
        '{2'd1, 2'd0, 4'h0, 8'd0,  2'd2, 1'b0, 4'h5, 1'b0, 1'b1, 4'd9 },  // R9 pll stop ignored
        '{2'd2, 2'd0, 4'h0, 8'd0,  2'd1, 1'b1, 4'h5, 1'b0, 1'b1, 4'd5 },  // R5 back to normal
        '{2'd1, 2'd2, 4'h3, 8'd0,  2'd1, 1'b1, 4'h3, 1'b0, 1'b1, 4'd8 },  // R8 write in normal
        '{2'd1, 2'd1, 4'h2, 8'd0,  2'd3, 1'b0, 4'h0, 1'b1, 1'b0, 4'd6 },  // R6 sleep from normal
        '{2'd1, 2'd2, 4'hF, 8'd0,  2'd3, 1'b0, 4'h0, 1'b1, 1'b0, 4'd8 },  // R8 ignored in sleep
        '{2'd2, 2'd0, 4'h0, 8'd0,  2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 4'd7 },  // R7 sleep wakes to slow
        '{2'd1, 2'd0, 4'h1, 8'd8,  2'd1, 1'b1, 4'h3, 1'b0, 1'b1, 4'd2 },  // R2 relock
        '{2'd1, 2'd0, 4'h0, 8'd0,  2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 4'd3 },  // R3 stop from normal
        '{2'd1, 2'd0, 4'h1, 8'd2,  2'd0, 1'b1, 4'h3, 1'b0, 1'b0, 4'd2 },  // R2 locking begins
        '{2'd1, 2'd1, 4'h1, 8'd0,  2'd0, 1'b1, 4'h3, 1'b0, 1'b0, 4'd10},  // R10 idle ignored
        '{2'd1, 2'd0, 4'h0, 8'd0,  2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 4'd11},  // R11 abort lock
        '{2'd0, 2'd0, 4'h0, 8'd10, 2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 4'd11},  // R11 never normal
        '{2'd1, 2'd1, 4'h3, 8'd0,  2'd3, 1'b0, 4'h0, 1'b1, 1'b0, 4'd6 },  // R6 sleep wins over idle
        '{2'd2, 2'd0, 4'h0, 8'd0,  2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 4'd12}   // R12 slow code after wake
    };

    task automatic check(input logic [1:0] m, input logic c, input logic [3:0] g,
                         input logic p, input logic s, input int r);
        checks++;
        if (mode_status !== m || cpu_clk_en !== c || grp_clk_en !== g ||
            pll_pwrdn !== p || pll_src_sel !== s) begin
            failures++;
            $display("FAIL R%0d: got mode=%0d cpu=%0b grp=%h pd=%0b src=%0b, expected mode=%0d cpu=%0b grp=%h pd=%0b src=%0b",
                     r, mode_status, cpu_clk_en, grp_clk_en, pll_pwrdn, pll_src_sel, m, c, g, p, s);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [3:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic do_wake();
        wake_in = 1;
        repeat (3) @(negedge clk);
        wake_in = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check(2'd0, 1'b1, 4'hF, 1'b1, 1'b0, 1);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == 2'd1) do_write(VECS[i].addr, VECS[i].data);
            else if (VECS[i].op == 2'd2) do_wake();
            repeat (int'(VECS[i].wait_n)) @(negedge clk);
            check(VECS[i].mode, VECS[i].cpu, VECS[i].grp, VECS[i].pd, VECS[i].src, int'(VECS[i].req));
        end

        // R5: wake latency of three edges, checked edge by edge
        do_write(2'd1, 4'h1);
        wake_in = 1;
        repeat (2) @(negedge clk);
        check(2'd2, 1'b0, 4'h3, 1'b1, 1'b0, 5);
        @(negedge clk);
        check(2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 5);
        // R5: wake held high in slow has no effect
        repeat (4) @(negedge clk);
        check(2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 5);
        wake_in = 0;
        repeat (3) @(negedge clk);

        // R12: normal code, then R1 reset from normal
        do_write(2'd0, 4'h1);
        repeat (LOCK) @(negedge clk);
        check(2'd1, 1'b1, 4'h3, 1'b0, 1'b1, 12);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(2'd0, 1'b1, 4'hF, 1'b1, 1'b0, 1);

        // R6: sleep from slow
        do_write(2'd1, 4'h2);
        check(2'd3, 1'b0, 4'h0, 1'b1, 1'b0, 6);
        do_wake();
        check(2'd0, 1'b1, 4'hF, 1'b1, 1'b0, 7);  // R7

        finish_run();
    end
endmodule